// File: doc/BRIEF.md
# Per-Privilege Tick Accumulator

This block keeps running totals of a free-running 64-bit tick count, with one total for each privilege level. There are two banks. One bank covers guest (virtualized) execution and the other covers host (native) execution. The block does not add to a counter on every cycle. It stores a start snapshot of the tick value for each mode and settles the account only when the core switches modes. At that point it subtracts the snapshot of the mode being left from the current tick and adds the difference to that mode's total. In the same cycle it stores the current tick as the start snapshot of the mode being entered.

The caller gives the privilege level and virtualization flag both before and after the switch, together with a one-cycle switch strobe. The block accepts a strobe on every cycle, so there is no back-pressure and no handshake. Any total can be read through a plain combinational read port addressed by bank and privilege code. Totals can count clock cycles or retired instructions, depending on which counter drives the tick input.

Top module: `priv_tick_accum`

## Requirements
- R1: While `rst_n` is low at a rising edge, every total in both banks is cleared to zero.
- R2: A reset loads every snapshot with the tick value present at that edge, so the first charge after reset equals the ticks elapsed since reset.
- R3: On an edge with `switch_i` high, the slot {`old_virt_i`, `old_priv_i`} gains `tick_i` minus that slot's stored snapshot. The bank is chosen by `old_virt_i`, where 1 means virtualized.
- R4: On an edge with `switch_i` high, the snapshot of slot {`new_virt_i`, `new_priv_i`} takes `tick_i`, in the bank chosen by `new_virt_i`. This can be a different bank from the one charged.
- R5: When the old and new slot are the same, the charge uses the snapshot from before this switch. The snapshot is then replaced.
- R6: The subtraction is modulo 2^64, so a tick source that wraps between two switches still produces the true elapsed count.
- R7: With `switch_i` low, no total and no snapshot changes, whatever the other inputs do.
- R8: Privilege codes are U=0, S=1 and M=3. All four 2-bit codes, including 2, have their own working slot. `rd_total_o` shows, in the same cycle, the total selected by `rd_virt_i` and `rd_priv_i`.
- R9: A switch changes no total other than the one for the old slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 64 | Free-running tick value |
| switch_i | input | 1 | Mode-change strobe, one cycle per switch |
| old_priv_i | input | 2 | Privilege code being left |
| old_virt_i | input | 1 | Virtualization flag being left |
| new_priv_i | input | 2 | Privilege code being entered |
| new_virt_i | input | 1 | Virtualization flag being entered |
| rd_virt_i | input | 1 | Read bank select (1 = virtualized) |
| rd_priv_i | input | 2 | Read privilege code |
| rd_total_o | output | 64 | Selected total |

## Verification
The bench targets the corner cases below. Each entry says what a faulty design would show.

- **Same-slot switch.** A design that writes the snapshot before it reads it would charge zero.
- **Switch that crosses banks.** A design that uses the new flag to pick the bank for the charge, or the old flag to pick the bank for the snapshot, would credit the wrong bank. The error shows up on the next switch.
- **Tick wrap.** The tick passes 2^64 between two switches. A design that saturates or sign-extends the difference would report a huge or truncated delta.
- **Reset in mid-run.** A design that clears snapshots to zero would charge the full tick value on the first switch instead of the ticks since reset.
- **Inputs changed with the strobe low.** A design that leaks an update would change a total.

// File: rtl/priv_tick_pkg.sv
package priv_tick_pkg;
  localparam int unsigned PRIV_W = 2;
  localparam int unsigned BANKS  = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_code_e;
endpackage

// File: rtl/pta_bank.sv
module pta_bank
  import priv_tick_pkg::*;
#(
  parameter int unsigned TICK_W = 64,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [TICK_W-1:0]              tick_i,
  input  logic                           chg_en,
  input  logic [IDX_W-1:0]               chg_idx,
  input  logic [TICK_W-1:0]              chg_delta,
  input  logic                           snap_en,
  input  logic [IDX_W-1:0]               snap_idx,
  output logic [SLOTS-1:0][TICK_W-1:0]   tot_o,
  output logic [SLOTS-1:0][TICK_W-1:0]   snap_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tot_o[s]  <= '0;
        snap_o[s] <= tick_i;
      end else begin
        if (chg_en && chg_idx == IDX_W'(s))
          tot_o[s] <= tot_o[s] + chg_delta;
        if (snap_en && snap_idx == IDX_W'(s))
          snap_o[s] <= tick_i;
      end
    end
  end
endmodule

// File: rtl/pta_delta.sv
module pta_delta #(
  parameter int unsigned TICK_W = 64,
  parameter int unsigned NSLOT  = 8,
  localparam int unsigned SEL_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0][TICK_W-1:0] snap_all,
  input  logic [SEL_W-1:0]             sel,
  input  logic [TICK_W-1:0]            tick_i,
  output logic [TICK_W-1:0]            delta_o
);
  logic [TICK_W-1:0] start_val;
  always_comb begin
    start_val = snap_all[sel];
    delta_o   = tick_i - start_val;
  end
endmodule

// File: rtl/priv_tick_accum.sv
module priv_tick_accum
  import priv_tick_pkg::*;
#(
  parameter int unsigned TICK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              switch_i,
  input  logic [1:0]        old_priv_i,
  input  logic              old_virt_i,
  input  logic [1:0]        new_priv_i,
  input  logic              new_virt_i,
  input  logic              rd_virt_i,
  input  logic [1:0]        rd_priv_i,
  output logic [TICK_W-1:0] rd_total_o
);
  localparam int unsigned SLOTS = 1 << PRIV_W;
  localparam int unsigned NSLOT = BANKS * SLOTS;
  localparam int unsigned SEL_W = $clog2(NSLOT);

  logic [NSLOT-1:0][TICK_W-1:0] tot_all;
  logic [NSLOT-1:0][TICK_W-1:0] snap_all;
  logic [TICK_W-1:0]            delta;
  logic [SEL_W-1:0]             old_sel;
  logic [SEL_W-1:0]             rd_sel;

  assign old_sel = {old_virt_i, old_priv_i};
  assign rd_sel  = {rd_virt_i, rd_priv_i};

  pta_delta #(.TICK_W(TICK_W), .NSLOT(NSLOT)) u_delta (
    .snap_all (snap_all),
    .sel      (old_sel),
    .tick_i   (tick_i),
    .delta_o  (delta)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic chg_en, snap_en;
    assign chg_en  = switch_i && (old_virt_i == 1'(b));
    assign snap_en = switch_i && (new_virt_i == 1'(b));

    pta_bank #(.TICK_W(TICK_W), .SLOTS(SLOTS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .chg_en    (chg_en),
      .chg_idx   (old_priv_i),
      .chg_delta (delta),
      .snap_en   (snap_en),
      .snap_idx  (new_priv_i),
      .tot_o     (tot_all[b*SLOTS +: SLOTS]),
      .snap_o    (snap_all[b*SLOTS +: SLOTS])
    );
  end

  assign rd_total_o = tot_all[rd_sel];
endmodule

// File: rtl/priv_tick_accum_chk.sv
module priv_tick_accum_chk #(
  parameter int unsigned TICK_W = 64,
  parameter int unsigned NSLOT  = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [TICK_W-1:0]            tick_i,
  input logic                         switch_i,
  input logic [1:0]                   old_priv_i,
  input logic                         old_virt_i,
  input logic [1:0]                   new_priv_i,
  input logic                         new_virt_i,
  input logic [NSLOT-1:0][TICK_W-1:0] tot_all,
  input logic [NSLOT-1:0][TICK_W-1:0] snap_all
);
  logic                         ck_rst_d, ck_live, ck_sw;
  logic [2:0]                   ck_oi, ck_ni;
  logic [TICK_W-1:0]            ck_tick_d, ck_exp;
  logic [NSLOT-1:0][TICK_W-1:0] ck_tot_d, ck_snap_d;

  always_ff @(posedge clk) begin
    ck_rst_d  <= !rst_n;
    ck_live   <= rst_n;
    ck_sw     <= switch_i && rst_n;
    ck_oi     <= {old_virt_i, old_priv_i};
    ck_ni     <= {new_virt_i, new_priv_i};
    ck_tick_d <= tick_i;
    ck_exp    <= tot_all[{old_virt_i, old_priv_i}] + (tick_i - snap_all[{old_virt_i, old_priv_i}]);
    ck_tot_d  <= tot_all;
    ck_snap_d <= snap_all;
  end

  p_reset_clears_r1: assert property (@(posedge clk) ck_rst_d |-> tot_all == '0);
  p_reset_snap_r2:   assert property (@(posedge clk) ck_rst_d |-> snap_all == {NSLOT{ck_tick_d}});
  p_charge_old_r3:   assert property (@(posedge clk) disable iff (!rst_n)
                       ck_live && ck_sw |-> tot_all[ck_oi] == ck_exp);
  p_snap_new_r4:     assert property (@(posedge clk) disable iff (!rst_n)
                       ck_live && ck_sw |-> snap_all[ck_ni] == ck_tick_d);
  p_idle_hold_r7:    assert property (@(posedge clk) disable iff (!rst_n)
                       ck_live && !ck_sw |-> (tot_all == ck_tot_d) && (snap_all == ck_snap_d));
endmodule

bind priv_tick_accum priv_tick_accum_chk #(.TICK_W(TICK_W), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .switch_i(switch_i),
  .old_priv_i(old_priv_i), .old_virt_i(old_virt_i),
  .new_priv_i(new_priv_i), .new_virt_i(new_virt_i),
  .tot_all(tot_all), .snap_all(snap_all)
);

// File: tb/tb_priv_tick_accum.sv
module tb_priv_tick_accum;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] tick;
  logic        sw;
  logic [1:0]  op, np, rp;
  logic        ov, nv, rv;
  logic [63:0] rd_total;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_tot  [8];
  logic [63:0] m_snap [8];

  always #10 clk = ~clk;

  priv_tick_accum dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .switch_i(sw),
    .old_priv_i(op), .old_virt_i(ov), .new_priv_i(np), .new_virt_i(nv),
    .rd_virt_i(rv), .rd_priv_i(rp), .rd_total_o(rd_total)
  );

  typedef struct packed {
    logic ov; logic [1:0] op; logic nv; logic [1:0] np; logic [63:0] tk;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 2'd0, 1'b0, 2'd1, 64'd1050},
    '{1'b0, 2'd1, 1'b0, 2'd3, 64'd1080},
    '{1'b0, 2'd3, 1'b1, 2'd1, 64'd1100},
    '{1'b1, 2'd1, 1'b1, 2'd0, 64'd1170},
    '{1'b1, 2'd0, 1'b1, 2'd0, 64'd1200},
    '{1'b1, 2'd0, 1'b1, 2'd0, 64'd1210},
    '{1'b1, 2'd0, 1'b0, 2'd2, 64'd1300},
    '{1'b0, 2'd2, 1'b0, 2'd0, 64'd1345}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic read_slot(input logic v, input logic [1:0] p, output logic [63:0] val);
    rv = v; rp = p;
    #2;
    val = rd_total;
  endtask

  task automatic check_all(input string req);
    logic [63:0] val;
    for (int i = 0; i < 8; i++) begin
      read_slot(i[2], i[1:0], val);
      chk(req, val, m_tot[i]);
    end
  endtask

  task automatic do_reset(input logic [63:0] tk);
    @(negedge clk);
    rst_n = 1'b0; sw = 1'b0; tick = tk;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin m_tot[i] = '0; m_snap[i] = tk; end
  endtask

  task automatic do_switch(input string req, input logic a_ov, input logic [1:0] a_op,
                           input logic b_nv, input logic [1:0] b_np, input logic [63:0] tk);
    logic [63:0] val;
    logic [2:0] oi, ni;
    oi = {a_ov, a_op}; ni = {b_nv, b_np};
    @(negedge clk);
    ov = a_ov; op = a_op; nv = b_nv; np = b_np; tick = tk; sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
    m_tot[oi] = m_tot[oi] + (tk - m_snap[oi]);
    m_snap[ni] = tk;
    read_slot(a_ov, a_op, val);
    chk(req, val, m_tot[oi]);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog got=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw = 1'b0; tick = '0;
    op = '0; np = '0; ov = 1'b0; nv = 1'b0; rv = 1'b0; rp = '0;

    // R1: reset clears every total
    do_reset(64'd1000);
    check_all("R1 reset totals");

    // R2 R3 R4 R5 R8: table walk (first entry charges ticks since reset;
    // entry 3 crosses banks; entries 5,6 are same-slot; entries 7,8 use code 2)
    for (int k = 0; k < 8; k++)
      do_switch("R3/R4/R5/R8 table", TBL[k].ov, TBL[k].op, TBL[k].nv, TBL[k].np, TBL[k].tk);

    // R9: no other total disturbed by the walk
    check_all("R9 untouched slots");

    // R7: inputs wiggle with the strobe low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      tick = 64'd9000 + 64'(k * 77);
      ov = k[0]; op = k[1:0]; nv = ~k[0]; np = ~k[1:0];
    end
    check_all("R7 idle hold");

    // R6: wrap of the tick source between two switches
    do_switch("R6 wrap setup", 1'b0, 2'd0, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFF6);
    do_switch("R6 wrap delta", 1'b0, 2'd3, 1'b0, 2'd0, 64'd25);
    check_all("R6 after wrap");

    // R2: mid-run reset reloads snapshots with the current tick
    do_reset(64'd5000);
    check_all("R1 second reset");
    do_switch("R2 ticks since reset", 1'b1, 2'd3, 1'b1, 2'd3, 64'd5007);
    do_switch("R5 same slot again", 1'b1, 2'd3, 1'b1, 2'd3, 64'd5010);
    check_all("R9 after reset run");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule